// File: doc/BRIEF.md
# Self-Routing Omega Cell Network

This block moves fixed-size cells from N input ports to N output ports through log2(N) columns of 2x2 switching elements. The columns are joined by a perfect-shuffle permutation, so every input/output pair has exactly one path. No central controller sets up connections. Each cell enters with a binary destination index. Every element looks at one bit of that index and sends the cell to its upper or lower output. Cells on separate paths advance together in the same cycle.

Two cells can meet at an element and ask for the same output in the same cycle. When that happens, the element lets one through and parks the other in a one-cell holding slot on the losing input. While that slot is occupied, the input drops its ready. Every port uses a valid/ready handshake, and a transfer happens on a rising clock edge where both are high. A slot counter is reset to 0 and advances once per cycle, and its parity decides which input wins a conflict.

Top module: `omega_net`

## Requirements
- R1: While reset is applied, and in the cycle after the reset edge, every out_valid bit is 0 and every in_ready bit is 1.
- R2: A cell accepted on any input appears on output port d with its data unchanged. Here d is the unsigned value of that input's LOG2N-bit field in_dest[i*LOG2N +: LOG2N], and out_dest for that port equals d.
- R3: With no contention and all outputs ready, a cell accepted at the clock edge that ends slot s shows out_valid during slot s+LOG2N.
- R4: Cells from one input to one output leave in the order they were accepted.
- R5: In the first column, input ports 0 and N/2 share an element, and port 0 is its upper input. If both present a cell to the same destination in the same slot, port 0 is delivered first when the slot number is even, and port N/2 is delivered first when it is odd. The loser arrives one slot after the winner.
- R6: A cell that loses a conflict stays in its element. That input's in_ready reads 0 in the next slot and returns to 1 once the cell moves on, while the winning input stays ready.
- R7: While out_ready is 0 on a port that holds a valid cell, out_valid and out_data on that port stay unchanged, and no cell is dropped.
- R8: Cells whose paths share no link all move in the same slots. Input i sent to (i+k) mod N for every i, all in one slot, makes every out_valid bit 1 together LOG2N slots later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N_PORTS | A cell is offered on each input |
| in_ready | output | N_PORTS | Each input can take a cell this cycle |
| in_dest | input | N_PORTS*LOG2N | Destination index per input |
| in_data | input | N_PORTS*DATA_W | Cell payload per input |
| out_valid | output | N_PORTS | A cell is presented on each output |
| out_ready | input | N_PORTS | Each output sink takes the cell |
| out_dest | output | N_PORTS*LOG2N | Destination index carried by each output cell |
| out_data | output | N_PORTS*DATA_W | Cell payload per output |

## Verification
A wrong routing bit or a miswired shuffle sends a cell to the wrong port within LOG2N slots. The scoreboard catches this from the source tag in the payload and from out_dest. A wrong arbitration parity swaps the arrival order of the two contending cells, and a holding slot that never clears leaves an input stuck not-ready; both show within two slots of the conflict. A cell lost or duplicated inside the network shows up when the per-pair queues are checked for emptiness after the final drain. A cell that changes under backpressure is caught in the first stalled slot.

// File: rtl/omega_pkg.sv
// Shared helpers for the omega network: index rotations used to build
// the perfect-shuffle wiring between columns. Assumes lg >= 1.
package omega_pkg;

    // Left rotation of a lg-bit line index (shuffle: source line -> position).
    function automatic int rotl(input int j, input int lg);
        return ((j << 1) | (j >> (lg - 1))) & ((1 << lg) - 1);
    endfunction

    // Right rotation of a lg-bit line index (position -> source line).
    function automatic int rotr(input int j, input int lg);
        return (j >> 1) | ((j & 1) << (lg - 1));
    endfunction

endpackage

// File: rtl/omega_sw2.sv
// 2x2 self-routing element. Each input's head cell is its holding slot
// if occupied, otherwise the incoming cell. Bit SEL_BIT of the head cell
// picks the output (0 upper, 1 lower). On a conflict, slot parity picks
// the winner (even: upper input). A loser that arrived fresh is parked in
// the holding slot; in_ready is the inverse of that slot's occupancy.
// Assumes the downstream ready depends only on downstream state.
module omega_sw2 #(
    parameter int CELL_W  = 19,
    parameter int SEL_BIT = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_odd,
    input  logic [1:0]          in_valid,
    output logic [1:0]          in_ready,
    input  logic [2*CELL_W-1:0] in_cell,
    output logic [1:0]          out_valid,
    input  logic [1:0]          out_ready,
    output logic [2*CELL_W-1:0] out_cell
);
    logic [1:0]        hold_v;
    logic [CELL_W-1:0] hold_c [2];
    logic [1:0]        out_v;
    logic [CELL_W-1:0] out_c [2];
    logic [1:0]        head_v, want, gnt, out_free, load, load_src;
    logic [CELL_W-1:0] head_c [2];
    logic              conflict;

    // Select each input's head cell and its requested output.
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            head_v[i] = hold_v[i] | in_valid[i];
            head_c[i] = hold_v[i] ? hold_c[i] : in_cell[i*CELL_W +: CELL_W];
            want[i]   = head_c[i][SEL_BIT];
        end
    end

    assign conflict = (&head_v) && (want[0] == want[1]);

    // Grant a head cell when its output register can load and it wins any conflict.
    always_comb begin
        for (int o = 0; o < 2; o++) begin
            out_free[o] = !out_v[o] || out_ready[o];
        end
        for (int i = 0; i < 2; i++) begin
            gnt[i] = head_v[i] && out_free[want[i]] &&
                     (!conflict || (slot_odd == 1'(i)));
        end
        for (int o = 0; o < 2; o++) begin
            load[o]     = (gnt[0] && (want[0] == 1'(o))) || (gnt[1] && (want[1] == 1'(o)));
            load_src[o] = !(gnt[0] && (want[0] == 1'(o)));
        end
    end

    // Output registers: load a granted cell, otherwise drain on ready.
    always_ff @(posedge clk) begin
        for (int o = 0; o < 2; o++) begin
            if (!rst_n) begin
                out_v[o] <= 1'b0;
            end else if (load[o]) begin
                out_v[o] <= 1'b1;
                out_c[o] <= head_c[load_src[o]];
            end else if (out_ready[o]) begin
                out_v[o] <= 1'b0;
            end
        end
    end

    // Holding slots: release on grant, capture a fresh cell that was not granted.
    always_ff @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                hold_v[i] <= 1'b0;
            end else if (hold_v[i]) begin
                if (gnt[i]) hold_v[i] <= 1'b0;
            end else if (in_valid[i] && !gnt[i]) begin
                hold_v[i] <= 1'b1;
                hold_c[i] <= in_cell[i*CELL_W +: CELL_W];
            end
        end
    end

    assign in_ready  = ~hold_v;
    assign out_valid = out_v;
    assign out_cell  = {out_c[1], out_c[0]};

    for (genvar o = 0; o < 2; o++) begin : g_out_chk
        // R2: a cell on output o always carries the matching routing bit.
        p_route_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_v[o] |-> (out_c[o][SEL_BIT] == 1'(o)));
        // R7: a stalled output keeps its cell.
        p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_v[o] && !out_ready[o]) |=> (out_v[o] && $stable(out_c[o])));
    end

    for (genvar i = 0; i < 2; i++) begin : g_hold_chk
        // R6: a parked cell that is not granted stays parked and unchanged.
        p_loser_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_v[i] && !gnt[i]) |=> (hold_v[i] && $stable(hold_c[i])));
    end

    // R5: even slots favour the upper input, odd slots the lower one.
    p_even_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && out_free[want[0]] && !slot_odd) |=> (hold_v[1] && !hold_v[0]));
    p_odd_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && out_free[want[0]] && slot_odd) |=> (hold_v[0] && !hold_v[1]));

endmodule

// File: rtl/omega_stage.sv
// One column of the omega network: a perfect shuffle of the N incoming
// lines followed by N/2 elements. Element e takes shuffled lines 2e
// (upper) and 2e+1 (lower) and drives outgoing lines 2e and 2e+1.
// Assumes N is a power of two and N >= 2.
module omega_stage #(
    parameter int N       = 8,
    parameter int LOG2N   = 3,
    parameter int CELL_W  = 19,
    parameter int SEL_BIT = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_odd,
    input  logic [N-1:0]        up_valid,
    output logic [N-1:0]        up_ready,
    input  logic [N*CELL_W-1:0] up_cell,
    output logic [N-1:0]        dn_valid,
    input  logic [N-1:0]        dn_ready,
    output logic [N*CELL_W-1:0] dn_cell
);
    logic [N-1:0]        sh_v, sh_r;
    logic [N*CELL_W-1:0] sh_c;

    // Shuffle wiring: position p is fed by line rotr(p); line p's ready comes from rotl(p).
    for (genvar p = 0; p < N; p++) begin : g_shuf
        localparam int SRC = omega_pkg::rotr(p, LOG2N);
        localparam int DST = omega_pkg::rotl(p, LOG2N);
        assign sh_v[p]                    = up_valid[SRC];
        assign sh_c[p*CELL_W +: CELL_W]   = up_cell[SRC*CELL_W +: CELL_W];
        assign up_ready[p]                = sh_r[DST];
    end

    // The column of 2x2 elements.
    for (genvar e = 0; e < N/2; e++) begin : g_sw
        omega_sw2 #(.CELL_W(CELL_W), .SEL_BIT(SEL_BIT)) u_sw (
            .clk       (clk),
            .rst_n     (rst_n),
            .slot_odd  (slot_odd),
            .in_valid  (sh_v[2*e +: 2]),
            .in_ready  (sh_r[2*e +: 2]),
            .in_cell   (sh_c[2*e*CELL_W +: 2*CELL_W]),
            .out_valid (dn_valid[2*e +: 2]),
            .out_ready (dn_ready[2*e +: 2]),
            .out_cell  (dn_cell[2*e*CELL_W +: 2*CELL_W])
        );
    end

endmodule

// File: rtl/omega_net.sv
// Top of the self-routing omega network: LOG2N shuffle+element columns.
// Column k routes on destination bit LOG2N-1-k (MSB first). A cell is
// {dest, data}. Holds the global slot parity used for arbitration.
// Assumes N_PORTS is a power of two, at least 2.
module omega_net #(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [N_PORTS-1:0]                 in_valid,
    output logic [N_PORTS-1:0]                 in_ready,
    input  logic [N_PORTS*$clog2(N_PORTS)-1:0] in_dest,
    input  logic [N_PORTS*DATA_W-1:0]          in_data,
    output logic [N_PORTS-1:0]                 out_valid,
    input  logic [N_PORTS-1:0]                 out_ready,
    output logic [N_PORTS*$clog2(N_PORTS)-1:0] out_dest,
    output logic [N_PORTS*DATA_W-1:0]          out_data
);
    localparam int LOG2N  = $clog2(N_PORTS);
    localparam int CELL_W = LOG2N + DATA_W;

    logic                      slot_odd;
    logic [N_PORTS-1:0]        lv [LOG2N+1];
    logic [N_PORTS-1:0]        lr [LOG2N+1];
    logic [N_PORTS*CELL_W-1:0] lc [LOG2N+1];
    logic [N_PORTS*CELL_W-1:0] cells_in;

    // Slot parity: 0 in the first slot after reset, toggles every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_odd <= 1'b0;
        else        slot_odd <= ~slot_odd;
    end

    // Pack port fields into cells and unpack the last column into ports.
    always_comb begin
        for (int i = 0; i < N_PORTS; i++) begin
            cells_in[i*CELL_W +: CELL_W]    = {in_dest[i*LOG2N +: LOG2N], in_data[i*DATA_W +: DATA_W]};
            out_data[i*DATA_W +: DATA_W]    = lc[LOG2N][i*CELL_W +: DATA_W];
            out_dest[i*LOG2N +: LOG2N]      = lc[LOG2N][i*CELL_W + DATA_W +: LOG2N];
        end
    end

    assign lv[0]      = in_valid;
    assign lc[0]      = cells_in;
    assign in_ready   = lr[0];
    assign out_valid  = lv[LOG2N];
    assign lr[LOG2N]  = out_ready;

    for (genvar k = 0; k < LOG2N; k++) begin : g_col
        omega_stage #(
            .N       (N_PORTS),
            .LOG2N   (LOG2N),
            .CELL_W  (CELL_W),
            .SEL_BIT (DATA_W + LOG2N - 1 - k)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .slot_odd (slot_odd),
            .up_valid (lv[k]),
            .up_ready (lr[k]),
            .up_cell  (lc[k]),
            .dn_valid (lv[k+1]),
            .dn_ready (lr[k+1]),
            .dn_cell  (lc[k+1])
        );
    end

endmodule

// File: tb/tb_omega_net.sv
// Scoreboard bench: the driver pushes each accepted cell into a queue per
// (source, destination) pair; the monitor pops and compares on delivery.
// Payload = {source[2:0], sequence[12:0]}.
module tb_omega_net;
    localparam int N  = 8;
    localparam int LG = 3;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0, in_ready, out_valid, out_ready = '1;
    logic [N*LG-1:0] in_dest = '0, out_dest;
    logic [N*DW-1:0] in_data = '0, out_data;

    always #4 clk = ~clk;

    omega_net #(.N_PORTS(N), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_dest(out_dest), .out_data(out_data)
    );

    int vectors = 0;
    int fails   = 0;
    int slot    = 0;
    logic [DW-1:0] expq [N*N][$];
    logic [N-1:0]  pv = '0;
    logic [N-1:0]  ordy = '1;
    logic [LG-1:0] pd [N];
    logic [DW-1:0] pdat [N];
    logic [12:0]   seq = '0;

    // Bench's own slot count, following R5's definition.
    always @(posedge clk) slot <= rst_n ? slot + 1 : 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic offer(input int src, input int dst);
        pv[src]   = 1'b1;
        pd[src]   = LG'(dst);
        pdat[src] = {3'(src), seq};
        seq++;
    endtask

    // One slot: drive, record accepted cells, advance past the edge.
    task automatic step();
        logic [N-1:0] acc;
        in_valid  = pv;
        out_ready = ordy;
        for (int i = 0; i < N; i++) begin
            in_dest[i*LG +: LG] = pd[i];
            in_data[i*DW +: DW] = pdat[i];
        end
        @(negedge clk);
        acc = pv & in_ready;
        for (int i = 0; i < N; i++)
            if (acc[i]) expq[i*N + int'(pd[i])].push_back(pdat[i]);
        @(posedge clk);
        #1;
        pv = pv & ~acc;
    endtask

    // Monitor: compare each delivered cell with its pair queue (R2, R4).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int o = 0; o < N; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    logic [DW-1:0] got;
                    int src;
                    got = out_data[o*DW +: DW];
                    src = int'(got[DW-1:DW-3]);
                    check(out_dest[o*LG +: LG] == LG'(o), "R2 out_dest", out_dest[o*LG +: LG], o);
                    if (expq[src*N + o].size() == 0) begin
                        check(1'b0, "R2 unexpected cell", got, 0);
                    end else begin
                        logic [DW-1:0] exp;
                        exp = expq[src*N + o].pop_front();
                        check(got == exp, "R4 order/R2 data", got, exp);
                    end
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            pd[i] = '0;
            pdat[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(out_valid == '0, "R1 out_valid", out_valid, 0);
        check(in_ready == '1, "R1 in_ready", in_ready, 8'hff);
        rst_n = 1'b1;
        step();
        check(out_valid == '0 && in_ready == '1, "R1 after reset", {out_valid, in_ready}, 16'h00ff);

        // R3: single uncontended cell, input 2 -> output 6
        begin
            logic [DW-1:0] d;
            offer(2, 6);
            d = pdat[2];
            step(); step();
            check(out_valid[6] == 1'b0, "R3 early", out_valid[6], 0);
            step();
            check(out_valid[6] == 1'b1, "R3 latency", out_valid[6], 1);
            check(out_data[6*DW +: DW] == d, "R3 data", out_data[6*DW +: DW], d);
            repeat (2) step();
        end

        // R5/R6: conflict in an even slot, upper (port 0) wins
        while (slot[0]) step();
        for (int odd = 0; odd < 2; odd++) begin
            logic [DW-1:0] d0, d4;
            if (odd == 1) while (!slot[0]) step();
            offer(0, 5);
            offer(4, 5);
            d0 = pdat[0];
            d4 = pdat[4];
            step();
            check(in_ready[odd ? 0 : 4] == 1'b0, "R6 loser not ready", in_ready, 0);
            check(in_ready[odd ? 4 : 0] == 1'b1, "R6 winner ready", in_ready, 1);
            step();
            check(in_ready[0] && in_ready[4], "R6 ready back", in_ready, 8'hff);
            step();
            check(out_valid[5] && out_data[5*DW +: DW] == (odd ? d4 : d0),
                  "R5 first winner", out_data[5*DW +: DW], odd ? d4 : d0);
            step();
            check(out_valid[5] && out_data[5*DW +: DW] == (odd ? d0 : d4),
                  "R5 second loser", out_data[5*DW +: DW], odd ? d0 : d4);
            repeat (2) step();
        end

        // R8: cyclic shift by 3 moves all cells together
        for (int i = 0; i < N; i++) offer(i, (i + 3) % N);
        repeat (3) step();
        check(out_valid == '1, "R8 all outputs", out_valid, 8'hff);
        repeat (2) step();

        // R7: stalled output keeps its cell; second cell queues behind it
        begin
            logic [DW-1:0] d1;
            ordy[1] = 1'b0;
            offer(7, 1);
            d1 = pdat[7];
            step();
            offer(7, 1);
            repeat (2) step();
            for (int k = 0; k < 4; k++) begin
                check(out_valid[1] == 1'b1, "R7 valid held", out_valid[1], 1);
                check(out_data[1*DW +: DW] == d1, "R7 data held", out_data[1*DW +: DW], d1);
                step();
            end
            ordy = '1;
            repeat (6) step();
        end

        // Mixed random traffic with random output backpressure (R2, R4, R6, R7)
        for (int c = 0; c < 1200; c++) begin
            for (int i = 0; i < N; i++)
                if (!pv[i] && ($urandom % 2 == 0)) offer(i, int'($urandom % N));
            ordy = N'($urandom) | N'($urandom);
            step();
        end
        pv = '0;
        ordy = '1;
        repeat (40) step();
        // R4/R7: no cell lost or left behind
        for (int q = 0; q < N*N; q++)
            check(expq[q].size() == 0, "R7 cell lost", expq[q].size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        fails++;
        vectors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule